// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a simple single-cycle processor core and decides, on every clock edge, which address the core fetches from next. From the instruction word the core is executing, plus two control strobes from the main decoder and the zero flag of the ALU, it forms three candidate addresses. The first is the sequential address, one word further on. The second is a conditional branch target, computed relative to the sequential address. The third is a jump target: a word index from the instruction placed inside the current 256 MiB region.

The register loads the selected address once per rising clock edge. The current address drives instruction fetch. The sequential address is also brought out, so that a link path or a test can observe it. Instruction memory, the register file and the ALU are outside this block: it only consumes the zero flag the ALU reports for a compare.

Top module: `next_pc_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pcCur` becomes 0x00000000 after that edge, whatever the other inputs are.
- R2: `pcPlus4` always equals `pcCur` + 4, modulo 2^32.
- R3: When `jumpEn` is low and `branchEn` is low, `pcCur` after the edge equals `pcCur` + 4 before it.
- R4: When `branchEn` and `aluZero` are both high and `jumpEn` is low, `pcCur` after the edge equals (`pcCur` + 4) + 4 × offset. The offset is `instrWord[15:0]` read as a two's-complement word count.
- R5: When `branchEn` is high and `aluZero` is low, or when `aluZero` is high and `branchEn` is low, with `jumpEn` low in both cases, the branch is not taken and `pcCur` advances by 4.
- R6: Bit 15 of the immediate is copied into all upper offset bits, so an offset of 0xFFFE moves the address two words below `pcCur` + 4, and 0x8000 moves it 0x20000 bytes below, wrapping modulo 2^32.
- R7: When `jumpEn` is high, `pcCur` after the edge is {(`pcCur` + 4)[31:28], `instrWord[25:0]`, 2'b00}.
- R8: When `jumpEn` and a taken branch are both requested, the jump wins.
- R9: The jump region bits come from `pcCur` + 4 and not from `pcCur`. A jump held in the last word of a region (`pcCur` = 0x0FFFFFFC) therefore lands in region 0x1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the address register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrWord | input | 32 | Instruction word now executing; immediate in [15:0], jump index in [25:0] |
| branchEn | input | 1 | Decoder marks the instruction as a conditional branch |
| jumpEn | input | 1 | Decoder marks the instruction as an unconditional jump |
| aluZero | input | 1 | ALU result of the compare was zero |
| pcCur | output | 32 | Current program counter |
| pcPlus4 | output | 32 | Sequential address, current counter plus 4 |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 16-bit immediate, a 26-bit jump index, word alignment of 2 bits and a reset address of zero. This leaves a 4-bit region field. A single jump with an all-ones index therefore reaches the last word of region 0, and the following jump shows the region coming from the sequential address. The full negative immediate range from a low address exercises wrap below zero. A long pseudo-random phase mixes all control combinations against a behavioural reference model.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // Source chosen for the next program counter value
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2,
    SRC_RESET  = 2'd3
  } pcSrc_e;

  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    pcSrc_e src;
    logic   load;
  } pcSel_t;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic   rst,
  input  logic   branchEn,
  input  logic   jumpEn,
  input  logic   aluZero,
  output pcSel_t sel
);

  logic branchTaken;

  always_comb begin
    branchTaken = branchEn && aluZero;
    sel.load    = 1'b1;
    if (rst) begin
      sel.src = SRC_RESET;
    end else if (jumpEn) begin
      sel.src = SRC_JUMP;       // jump outranks a taken branch
    end else if (branchTaken) begin
      sel.src = SRC_BRANCH;
    end else begin
      sel.src = SRC_SEQ;
    end
  end

endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 32,
  parameter int unsigned          INSTR_W  = 32,
  parameter int unsigned          IMM_W    = 16,
  parameter int unsigned          TGT_W    = 26,
  parameter int unsigned          ALIGN_SH = 2,
  parameter logic [ADDR_W-1:0]    RESET_PC = '0
) (
  input  logic               clk,
  input  pcSel_t             sel,
  input  logic [INSTR_W-1:0] instrWord,
  output logic [ADDR_W-1:0]  pcCur,
  output logic [ADDR_W-1:0]  pcPlus4
);

  localparam int unsigned EXT_W    = ADDR_W - IMM_W - ALIGN_SH;
  localparam int unsigned REGION_W = ADDR_W - TGT_W - ALIGN_SH;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_SH;

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] branchOff;
  logic [ADDR_W-1:0] branchAddr;
  logic [ADDR_W-1:0] jumpAddr;
  logic [ADDR_W-1:0] pcNext;
  logic [IMM_W-1:0]  immField;
  logic [TGT_W-1:0]  tgtField;

  assign immField = instrWord[IMM_W-1:0];
  assign tgtField = instrWord[TGT_W-1:0];

  // Sequential adder
  assign seqAddr = pcQ + STEP;

  // Sign extension and word scaling of the branch immediate
  assign branchOff  = {{EXT_W{immField[IMM_W-1]}}, immField, {ALIGN_SH{1'b0}}};
  assign branchAddr = seqAddr + branchOff;

  // Jump target keeps the region bits of the sequential address
  generate
    if (REGION_W > 0) begin : g_region
      assign jumpAddr = {seqAddr[ADDR_W-1 -: REGION_W], tgtField, {ALIGN_SH{1'b0}}};
    end else begin : g_flat
      assign jumpAddr = ADDR_W'({tgtField, {ALIGN_SH{1'b0}}});
    end
  endgenerate

  always_comb begin
    unique case (sel.src)
      SRC_RESET:  pcNext = RESET_PC;
      SRC_JUMP:   pcNext = jumpAddr;
      SRC_BRANCH: pcNext = branchAddr;
      default:    pcNext = seqAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (sel.load) pcQ <= pcNext;
  end

  assign pcCur   = pcQ;
  assign pcPlus4 = seqAddr;

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import pcu_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       INSTR_W  = 32,
  parameter int unsigned       IMM_W    = 16,
  parameter int unsigned       TGT_W    = 26,
  parameter int unsigned       ALIGN_SH = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               branchEn,
  input  logic               jumpEn,
  input  logic               aluZero,
  output logic [ADDR_W-1:0]  pcCur,
  output logic [ADDR_W-1:0]  pcPlus4
);

  pcSel_t sel;

  pcu_ctrl u_ctrl (
    .rst      (rst),
    .branchEn (branchEn),
    .jumpEn   (jumpEn),
    .aluZero  (aluZero),
    .sel      (sel)
  );

  pcu_datapath #(
    .ADDR_W   (ADDR_W),
    .INSTR_W  (INSTR_W),
    .IMM_W    (IMM_W),
    .TGT_W    (TGT_W),
    .ALIGN_SH (ALIGN_SH),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk       (clk),
    .sel       (sel),
    .instrWord (instrWord),
    .pcCur     (pcCur),
    .pcPlus4   (pcPlus4)
  );

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       INSTR_W  = 32,
  parameter int unsigned       IMM_W    = 16,
  parameter int unsigned       TGT_W    = 26,
  parameter int unsigned       ALIGN_SH = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instrWord,
  input logic               branchEn,
  input logic               jumpEn,
  input logic               aluZero,
  input logic [ADDR_W-1:0]  pcCur,
  input logic [ADDR_W-1:0]  pcPlus4
);

  localparam int unsigned REGION_W = ADDR_W - TGT_W - ALIGN_SH;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_SH;

  p_reset_load_r1: assert property (@(posedge clk)
    rst |=> pcCur == RESET_PC);

  p_seq_link_r2: assert property (@(posedge clk) disable iff (rst)
    pcPlus4 - pcCur == STEP);

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!jumpEn && !branchEn) |=> pcCur == $past(pcCur) + STEP);

  p_branch_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (branchEn && aluZero && !jumpEn) |=>
      pcCur == $past(pcPlus4) +
               (ADDR_W'($signed($past(instrWord[IMM_W-1:0]))) << ALIGN_SH));

  p_branch_untaken_r5: assert property (@(posedge clk) disable iff (rst)
    (branchEn && !aluZero && !jumpEn) |=> pcCur == $past(pcCur) + STEP);

  p_jump_index_r7: assert property (@(posedge clk) disable iff (rst)
    jumpEn |=> pcCur[TGT_W+ALIGN_SH-1:ALIGN_SH] == $past(instrWord[TGT_W-1:0]));

  // R8: jump wins over a taken branch, so the low bits stay aligned too
  p_jump_priority_r8: assert property (@(posedge clk) disable iff (rst)
    (jumpEn && branchEn && aluZero) |=>
      (pcCur[TGT_W+ALIGN_SH-1:ALIGN_SH] == $past(instrWord[TGT_W-1:0]) &&
       pcCur[ALIGN_SH-1:0] == '0));

  p_jump_region_r9: assert property (@(posedge clk) disable iff (rst)
    jumpEn |=> pcCur[ADDR_W-1 -: REGION_W] == $past(pcPlus4[ADDR_W-1 -: REGION_W]));

endmodule

bind next_pc_unit pcu_checker #(
  .ADDR_W   (ADDR_W),
  .INSTR_W  (INSTR_W),
  .IMM_W    (IMM_W),
  .TGT_W    (TGT_W),
  .ALIGN_SH (ALIGN_SH),
  .RESET_PC (RESET_PC)
) u_pcu_checker (
  .clk       (clk),
  .rst       (rst),
  .instrWord (instrWord),
  .branchEn  (branchEn),
  .jumpEn    (jumpEn),
  .aluZero   (aluZero),
  .pcCur     (pcCur),
  .pcPlus4   (pcPlus4)
);

// File: tb/tb_next_pc_unit.sv
`timescale 1ns/1ps
module tb_next_pc_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instrWord;
  logic        branchEn, jumpEn, aluZero;
  logic [31:0] pcCur, pcPlus4;

  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  bit          pendValid = 0;
  string       pendTag = "";
  logic [31:0] refPc;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;   // 125 MHz

  next_pc_unit dut (
    .clk       (clk),
    .rst       (rst),
    .instrWord (instrWord),
    .branchEn  (branchEn),
    .jumpEn    (jumpEn),
    .aluZero   (aluZero),
    .pcCur     (pcCur),
    .pcPlus4   (pcPlus4)
  );

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model of the next address
  function automatic logic [31:0] model(logic [31:0] pc, logic [31:0] ins,
                                        bit br, bit jp, bit z, bit rs);
    longint seqA, off;
    if (rs) return 32'h0;
    seqA = longint'(pc) + 4;
    if (jp) return (32'(seqA) & 32'hF000_0000) | (32'(ins % (1 << 26)) * 4);
    if (br && z) begin
      off = longint'(ins[15:0]);
      if (off >= 32768) off = off - 65536;
      return 32'(seqA + off * 4);
    end
    return 32'(seqA);
  endfunction

  // One cycle: check the outcome of the previous cycle, then drive new inputs
  task automatic step(logic [31:0] ins, bit br, bit jp, bit z, bit rs, string tag);
    @(negedge clk);
    if (pendValid) begin
      checkEq(pendTag, pcCur, refPc);
      checkEq("R2", pcPlus4, refPc + 32'd4);
    end
    rst = rs; instrWord = ins; branchEn = br; jumpEn = jp; aluZero = z;
    refPc = model(refPc, ins, br, jp, z, rs);
    pendTag = tag;
    pendValid = 1;
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  initial begin
    rst = 1; instrWord = '0; branchEn = 0; jumpEn = 0; aluZero = 0;
    refPc = '0;
    step(32'hFFFF_FFFF, 1, 1, 1, 1, "R1");
    step(32'h0000_0000, 0, 0, 0, 1, "R1");
    // sequential stepping
    step(32'h0000_0003, 0, 0, 1, 0, "R3");
    step(32'h0000_0007, 0, 0, 0, 0, "R3");
    // positive taken branch from 0x8: 0xC + 12 = 0x18
    step(32'h0000_0003, 1, 0, 1, 0, "R4");
    // untaken: zero low, then enable low
    step(32'h0000_0040, 1, 0, 0, 0, "R5");
    step(32'h0000_0040, 0, 0, 1, 0, "R5");
    // negative offsets
    step(32'h0000_FFFE, 1, 0, 1, 0, "R6");
    step(32'h0000_8000, 1, 0, 1, 0, "R6");
    step(32'h0000_7FFF, 1, 0, 1, 0, "R4");
    // jump to last word of region 0
    step(32'h03FF_FFFF, 0, 1, 0, 0, "R7");
    // jump from 0x0FFFFFFC: region comes from pc+4
    step(32'h0000_0005, 0, 1, 0, 0, "R9");
    // jump and taken branch together
    step(32'h0000_0100, 1, 1, 1, 0, "R8");
    step(32'h0000_0010, 0, 0, 0, 0, "R3");
    // pseudo-random phase
    for (int i = 0; i < 2500; i++) begin
      logic [31:0] r, ins;
      bit br, jp, z;
      r   = nextRand();
      ins = nextRand();
      jp  = (r[2:0] == 3'd0);
      br  = (r[5:4] != 2'd0);
      z   = r[8];
      step(ins, br, jp, z, 0, jp ? (br && z ? "R8" : "R7") : (br && z ? "R4" : "R5"));
    end
    // reset in the middle of traffic, with a jump requested
    step(32'h0123_4567, 1, 1, 1, 1, "R1");
    step(32'h0000_0000, 0, 0, 0, 0, "R3");
    step(32'h0000_0000, 0, 0, 0, 0, "R3");
    @(negedge clk);
    checkEq(pendTag, pcCur, refPc);
    checkEq("R2", pcPlus4, refPc + 32'd4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule